// File: doc/BRIEF.md
# HDLC Frame Check Sequence Residue Checker

This block sits behind an HDLC deframer that has already stripped flags and removed stuffed zero bits. It takes the resulting byte stream, with strobes that mark the first byte, the last byte and an abort, and checks each frame's frame check sequence (FCS). The data bytes and the received FCS bytes all pass through one running CRC. The final register is then compared with a fixed good-frame residue, so no stored FCS is ever extracted. A mode input selects a 16-bit or a 32-bit check for each frame.

Alongside the CRC check, the block counts the bytes in each frame against a programmable maximum. It reports a one-cycle status word for every completed or aborted frame. Two wrapping statistics counters record CRC failures and aborted frames, and a small register port lets the host read or load either counter.

Top module: `hdlc_fcs_check`

## Requirements
- R1: After reset, st_valid, st_crc_err, st_len_err and st_abort are 0, and both counters read 0.
- R2: With mode32=0 sampled with the start byte, the CRC uses x^16+x^12+x^5+1 with bits taken least significant first and a preset of all ones. A frame whose FCS is the complement of that CRC over the payload, sent low byte first, is good: the final register equals 0xF0B8. Any other final value sets st_crc_err.
- R3: With mode32=1 sampled with the start byte, the CRC uses the Ethernet polynomial with bits taken least significant first and a preset of all ones. A frame carrying the complemented 32-bit CRC as four bytes, least significant byte first, is good: the final register equals 0xDEBB20E3. Any other final value sets st_crc_err.
- R4: st_valid is high for exactly one cycle, in the cycle after the clock edge that takes the end byte (rx_valid and rx_eof) or the abort strobe. Outside that cycle all status bits are 0.
- R5: The frame length counts every byte from the start byte to the end byte, FCS included. st_len_err is 1 when that length is greater than max_len; a length equal to max_len is accepted.
- R6: rx_abort while a frame is open ends the frame with st_abort=1, st_crc_err=0 and st_len_err=0, and adds 1 to the abort counter without changing the CRC error counter. rx_abort while no frame is open has no effect.
- R7: The CRC error counter (register address 0) adds 1 for each non-aborted frame that fails its residue check.
- R8: Both counters wrap from 0xFFFF to 0x0000.
- R9: reg_wr with reg_addr=0 loads the CRC error counter and with reg_addr=1 loads the abort counter from reg_wdata. reg_rdata shows the addressed counter combinationally, and a write takes priority over an increment in the same cycle.
- R10: Each start byte (rx_valid with rx_sof) presets the CRC and restarts the length count, even when a frame is already open.
- R11: A byte given while no frame is open and without rx_sof is ignored. An rx_eof on such a byte produces no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | 1 selects the 32-bit check, 0 the 16-bit check; sampled with the start byte |
| max_len | input | 16 | Largest accepted frame length in bytes |
| rx_valid | input | 1 | rx_data holds a byte |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_abort | input | 1 | Abort strobe ending the open frame |
| reg_wr | input | 1 | Counter write enable |
| reg_addr | input | 1 | Counter select: 0 CRC errors, 1 aborts |
| reg_wdata | input | 16 | Counter load value |
| reg_rdata | output | 16 | Selected counter value |
| st_valid | output | 1 | Frame status valid pulse |
| st_crc_err | output | 1 | Residue check failed |
| st_len_err | output | 1 | Frame longer than max_len |
| st_abort | output | 1 | Frame ended by abort |

## Verification
The bench builds the block with its default parameters: 16-bit length and counter widths and the 32-bit lane present. Both residue modes can therefore be exercised in one run, and a counter load of 0xFFFE brings the wrap within two frames. With the full 16-bit max_len, the table can place frames exactly at and one byte past the length limit, for both FCS sizes.

// File: rtl/hdlc_fcs_pkg.sv
package hdlc_fcs_pkg;
   // Reflected generator constants (bit 0 = highest-order coefficient)
   localparam logic [15:0] POLY16_REFL = 16'h8408;
   localparam logic [31:0] POLY32_REFL = 32'hEDB8_8320;

   typedef enum logic {
      CSR_CRC_ERRS = 1'b0,
      CSR_ABORTS   = 1'b1
   } csr_sel_e;

   typedef struct packed {
      logic valid;
      logic crc_err;
      logic len_err;
      logic abort;
   } frame_stat_t;
endpackage

// File: rtl/fcs_crc_lane.sv
module fcs_crc_lane #(
   parameter int              W    = 16,
   parameter logic [W-1:0]    POLY = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         load,
   input  logic [7:0]   data,
   output logic [W-1:0] crc_nxt
);
   logic [W-1:0] crc_q;
   logic [W-1:0] acc;
   logic         fb;

   // Byte step, least significant bit first
   always_comb begin
      acc = restart ? {W{1'b1}} : crc_q;
      fb  = 1'b0;
      for (int b = 0; b < 8; b++) begin
         fb  = acc[0] ^ data[b];
         acc = acc >> 1;
         if (fb) acc = acc ^ POLY;
      end
      crc_nxt = acc;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    crc_q <= {W{1'b1}};
      else if (load) crc_q <= crc_nxt;
   end
endmodule

// File: rtl/frame_len_track.sv
module frame_len_track #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             load,
   input  logic [LEN_W-1:0] limit,
   output logic             over_nxt
);
   localparam int CW = LEN_W + 1;

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_nxt;

   always_comb begin
      if (restart)               cnt_nxt = CW'(1);
      else if (&cnt_q)           cnt_nxt = cnt_q;
      else                       cnt_nxt = cnt_q + CW'(1);
      over_nxt = cnt_nxt > {1'b0, limit};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (load) cnt_q <= cnt_nxt;
   end
endmodule

// File: rtl/stat_counter.sv
module stat_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (wr)  q <= wdata;
      else if (inc) q <= q + CNT_W'(1);
   end
endmodule

// File: rtl/hdlc_fcs_check.sv
module hdlc_fcs_check #(
   parameter int          LEN_W      = 16,
   parameter int          CNT_W      = 16,
   parameter bit          HAS_CRC32  = 1'b1,
   parameter logic [15:0] RESID16    = 16'hF0B8,
   parameter logic [15:0] RESID32_UP = 16'hDEBB,
   parameter logic [15:0] RESID32_DN = 16'h20E3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode32,
   input  logic [LEN_W-1:0] max_len,
   input  logic             rx_valid,
   input  logic [7:0]       rx_data,
   input  logic             rx_sof,
   input  logic             rx_eof,
   input  logic             rx_abort,
   input  logic             reg_wr,
   input  logic             reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   output logic             st_valid,
   output logic             st_crc_err,
   output logic             st_len_err,
   output logic             st_abort
);
   import hdlc_fcs_pkg::*;

   localparam logic [31:0] RESID32 = {RESID32_UP, RESID32_DN};

   if (LEN_W < 4 || LEN_W > 32) begin : g_bad_len_w
      $error("hdlc_fcs_check: LEN_W must lie in 4..32");
   end
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt_w
      $error("hdlc_fcs_check: CNT_W must lie in 2..32");
   end

   logic        in_frame_q;
   logic        mode_q;
   logic        mode_cur;
   logic        byte_ok;
   logic        frame_end;
   logic        abort_ev;
   logic        len_over;
   logic        good16;
   logic        good32;
   logic        crc_bad;
   logic [15:0] crc16_nxt;
   logic [CNT_W-1:0] crc_cnt_q;
   logic [CNT_W-1:0] abt_cnt_q;
   frame_stat_t stat_q;

   assign byte_ok   = rx_valid && !rx_abort && (rx_sof || in_frame_q);
   assign frame_end = byte_ok && rx_eof;
   assign abort_ev  = rx_abort && in_frame_q;
   assign mode_cur  = rx_sof ? mode32 : mode_q;

   fcs_crc_lane #(.W(16), .POLY(POLY16_REFL)) u_lane16 (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (rx_sof),
      .load    (byte_ok),
      .data    (rx_data),
      .crc_nxt (crc16_nxt)
   );
   assign good16 = (crc16_nxt == RESID16);

   if (HAS_CRC32) begin : g_lane32
      logic [31:0] crc32_nxt;
      fcs_crc_lane #(.W(32), .POLY(POLY32_REFL)) u_lane32 (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (rx_sof),
         .load    (byte_ok),
         .data    (rx_data),
         .crc_nxt (crc32_nxt)
      );
      assign good32 = (crc32_nxt == RESID32);
   end else begin : g_no_lane32
      assign good32 = 1'b0;
   end

   assign crc_bad = (mode_cur && HAS_CRC32) ? !good32 : !good16;

   frame_len_track #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (rx_sof),
      .load     (byte_ok),
      .limit    (max_len),
      .over_nxt (len_over)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         mode_q     <= 1'b0;
         stat_q     <= '0;
      end else begin
         if (abort_ev)     in_frame_q <= 1'b0;
         else if (byte_ok) in_frame_q <= !rx_eof;
         if (byte_ok && rx_sof) mode_q <= mode32;
         stat_q.valid   <= frame_end || abort_ev;
         stat_q.crc_err <= frame_end && crc_bad;
         stat_q.len_err <= frame_end && len_over;
         stat_q.abort   <= abort_ev;
      end
   end

   stat_counter #(.CNT_W(CNT_W)) u_crc_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (frame_end && crc_bad),
      .wr    (reg_wr && (reg_addr == CSR_CRC_ERRS)),
      .wdata (reg_wdata),
      .q     (crc_cnt_q)
   );

   stat_counter #(.CNT_W(CNT_W)) u_abt_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (abort_ev),
      .wr    (reg_wr && (reg_addr == CSR_ABORTS)),
      .wdata (reg_wdata),
      .q     (abt_cnt_q)
   );

   assign reg_rdata  = (reg_addr == CSR_ABORTS) ? abt_cnt_q : crc_cnt_q;
   assign st_valid   = stat_q.valid;
   assign st_crc_err = stat_q.crc_err;
   assign st_len_err = stat_q.len_err;
   assign st_abort   = stat_q.abort;
endmodule

// File: rtl/hdlc_fcs_check_sva.sv
module hdlc_fcs_check_sva #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_valid,
   input logic             rx_eof,
   input logic             rx_abort,
   input logic             reg_wr,
   input logic             reg_addr,
   input logic             st_valid,
   input logic             st_crc_err,
   input logic             st_len_err,
   input logic             st_abort,
   input logic [CNT_W-1:0] crc_cnt_q,
   input logic [CNT_W-1:0] abt_cnt_q
);
   // R4
   status_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> $past((rx_valid && rx_eof) || rx_abort));

   // R4
   status_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !st_valid |-> !(st_crc_err || st_len_err || st_abort));

   // R6
   abort_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_abort) |-> !(st_crc_err || st_len_err));

   // R6
   abort_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_abort && !$past(reg_wr && reg_addr))
         |-> abt_cnt_q == $past(abt_cnt_q) + CNT_W'(1));

   // R7
   crc_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(st_valid && st_crc_err) && !$past(reg_wr && !reg_addr))
         |-> $stable(crc_cnt_q));
endmodule

bind hdlc_fcs_check hdlc_fcs_check_sva #(.CNT_W(CNT_W)) u_sva (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_eof     (rx_eof),
   .rx_abort   (rx_abort),
   .reg_wr     (reg_wr),
   .reg_addr   (reg_addr),
   .st_valid   (st_valid),
   .st_crc_err (st_crc_err),
   .st_len_err (st_len_err),
   .st_abort   (st_abort),
   .crc_cnt_q  (crc_cnt_q),
   .abt_cnt_q  (abt_cnt_q)
);

// File: tb/test_hdlc_fcs_check.sv
module test_hdlc_fcs_check;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode32 = 1'b0;
   logic [15:0] max_len = 16'd100;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = 8'h00;
   logic        rx_sof = 1'b0;
   logic        rx_eof = 1'b0;
   logic        rx_abort = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_addr = 1'b0;
   logic [15:0] reg_wdata = 16'h0000;
   logic [15:0] reg_rdata;
   logic        st_valid, st_crc_err, st_len_err, st_abort;

   int n_chk = 0;
   int n_bad = 0;
   int exp_crc_cnt = 0;
   int exp_abt_cnt = 0;

   logic [7:0] fr [0:79];
   int         fr_len;

   always #10 clk = ~clk;   // 50 MHz

   hdlc_fcs_check i_hdlc_fcs_check (
      .clk(clk), .rst_n(rst_n), .mode32(mode32), .max_len(max_len),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof),
      .rx_eof(rx_eof), .rx_abort(rx_abort), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .st_valid(st_valid), .st_crc_err(st_crc_err),
      .st_len_err(st_len_err), .st_abort(st_abort)
   );

   typedef struct packed {
      logic        m32;
      logic [7:0]  npay;
      logic [7:0]  seed;
      logic        corrupt;
      logic [15:0] maxl;
      logic        exp_crc;
      logic        exp_len;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b0, 8'd5,  8'd1, 1'b0, 16'd100, 1'b0, 1'b0},   // R2 good
      '{1'b0, 8'd5,  8'd1, 1'b1, 16'd100, 1'b1, 1'b0},   // R2 bad
      '{1'b1, 8'd8,  8'd2, 1'b0, 16'd100, 1'b0, 1'b0},   // R3 good
      '{1'b1, 8'd8,  8'd2, 1'b1, 16'd100, 1'b1, 1'b0},   // R3 bad
      '{1'b0, 8'd10, 8'd3, 1'b0, 16'd12,  1'b0, 1'b0},   // R5 equal
      '{1'b0, 8'd10, 8'd3, 1'b0, 16'd11,  1'b0, 1'b1},   // R5 over
      '{1'b1, 8'd1,  8'd4, 1'b0, 16'd5,   1'b0, 1'b0},   // R5 equal, 32
      '{1'b1, 8'd20, 8'd5, 1'b1, 16'd23,  1'b1, 1'b1},   // R5 over + bad
      '{1'b0, 8'd0,  8'd6, 1'b0, 16'd100, 1'b0, 1'b0},   // R2 FCS only
      '{1'b1, 8'd40, 8'd7, 1'b0, 16'd44,  1'b0, 1'b0}    // R3 long
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] step16(input logic [15:0] c, input logic [7:0] d);
      logic [15:0] r = c;
      for (int b = 0; b < 8; b++)
         r = (r[0] ^ d[b]) ? ((r >> 1) ^ 16'h8408) : (r >> 1);
      return r;
   endfunction

   function automatic logic [31:0] step32(input logic [31:0] c, input logic [7:0] d);
      logic [31:0] r = c;
      for (int b = 0; b < 8; b++)
         r = (r[0] ^ d[b]) ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
      return r;
   endfunction

   task automatic build(input logic m32, input int npay, input logic [7:0] seed,
                        input logic corrupt);
      logic [15:0] c16 = 16'hFFFF;
      logic [31:0] c32 = 32'hFFFF_FFFF;
      for (int i = 0; i < npay; i++) begin
         fr[i] = 8'(seed * 7 + i * 13 + 3);
         c16 = step16(c16, fr[i]);
         c32 = step32(c32, fr[i]);
      end
      c16 = ~c16;
      c32 = ~c32;
      if (m32) begin
         for (int k = 0; k < 4; k++) fr[npay + k] = c32[8*k +: 8];
         fr_len = npay + 4;
      end else begin
         fr[npay] = c16[7:0];
         fr[npay + 1] = c16[15:8];
         fr_len = npay + 2;
      end
      if (corrupt) fr[0] = fr[0] ^ 8'h01;
   endtask

   // Drive fr[0..fr_len-1]; on return the status cycle is current.
   task automatic drive_frame(input logic with_eof);
      for (int i = 0; i < fr_len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_data  = fr[i];
         rx_sof   = (i == 0);
         rx_eof   = with_eof && (i == fr_len - 1);
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
   endtask

   task automatic read_reg(input logic a, output logic [15:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 st_valid", st_valid, 0);
      chk("R1 status bits", {st_crc_err, st_len_err, st_abort}, 0);
      read_reg(1'b0, v); chk("R1 crc counter", v, 0);
      read_reg(1'b1, v); chk("R1 abort counter", v, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R2 R3 R4 R5 R7
      for (int n = 0; n < NV; n++) begin
         mode32  = VEC[n].m32;
         max_len = VEC[n].maxl;
         build(VEC[n].m32, int'(VEC[n].npay), VEC[n].seed, VEC[n].corrupt);
         drive_frame(1'b1);
         chk("R4 st_valid pulse", st_valid, 1);
         chk(VEC[n].m32 ? "R3 crc_err" : "R2 crc_err", st_crc_err, VEC[n].exp_crc);
         chk("R5 len_err", st_len_err, VEC[n].exp_len);
         chk("R4 no abort", st_abort, 0);
         if (VEC[n].exp_crc) exp_crc_cnt++;
         @(negedge clk);
         chk("R4 pulse ends", st_valid, 0);
         read_reg(1'b0, v); chk("R7 crc counter", v, 16'(exp_crc_cnt));
      end

      // R10: open frame restarted by a new start byte
      mode32 = 1'b0;
      build(1'b0, 6, 8'd9, 1'b0);
      fr_len = 3;
      drive_frame(1'b0);
      build(1'b0, 6, 8'd11, 1'b0);
      max_len = 16'd8;
      drive_frame(1'b1);
      chk("R10 restart crc_err", st_crc_err, 0);
      chk("R10 restart len_err", st_len_err, 0);

      // R6: abort inside a frame
      max_len = 16'd1;
      build(1'b0, 6, 8'd12, 1'b1);
      fr_len = 3;
      drive_frame(1'b0);
      rx_abort = 1'b1;
      @(negedge clk);
      rx_abort = 1'b0;
      chk("R6 abort valid", st_valid, 1);
      chk("R6 abort flag", st_abort, 1);
      chk("R6 abort suppresses", {st_crc_err, st_len_err}, 0);
      exp_abt_cnt++;
      read_reg(1'b1, v); chk("R6 abort counter", v, 16'(exp_abt_cnt));
      read_reg(1'b0, v); chk("R6 crc counter unchanged", v, 16'(exp_crc_cnt));

      // R6: abort with no open frame
      @(negedge clk);
      rx_abort = 1'b1;
      @(negedge clk);
      rx_abort = 1'b0;
      chk("R6 idle abort no status", st_valid, 0);
      read_reg(1'b1, v); chk("R6 idle abort counter", v, 16'(exp_abt_cnt));

      // R11: stray end byte outside a frame
      rx_valid = 1'b1; rx_eof = 1'b1; rx_data = 8'h5A;
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
      chk("R11 stray byte no status", st_valid, 0);

      // R9 load, R8 wrap
      max_len = 16'd100;
      reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 16'hFFFE;
      @(negedge clk);
      reg_wr = 1'b0;
      read_reg(1'b0, v); chk("R9 load crc counter", v, 16'hFFFE);
      build(1'b0, 4, 8'd13, 1'b1);
      drive_frame(1'b1);
      read_reg(1'b0, v); chk("R8 crc counter 0xFFFF", v, 16'hFFFF);
      build(1'b0, 4, 8'd14, 1'b1);
      drive_frame(1'b1);
      read_reg(1'b0, v); chk("R8 crc counter wraps", v, 16'h0000);

      reg_wr = 1'b1; reg_addr = 1'b1; reg_wdata = 16'hFFFF;
      @(negedge clk);
      reg_wr = 1'b0;
      read_reg(1'b1, v); chk("R9 load abort counter", v, 16'hFFFF);
      build(1'b1, 4, 8'd15, 1'b0);
      fr_len = 2;
      drive_frame(1'b0);
      rx_abort = 1'b1;
      @(negedge clk);
      rx_abort = 1'b0;
      read_reg(1'b1, v); chk("R8 abort counter wraps", v, 16'h0000);

      // R9 write wins over increment in the same cycle
      build(1'b0, 4, 8'd16, 1'b1);
      for (int i = 0; i < fr_len; i++) begin
         @(negedge clk);
         rx_valid = 1'b1; rx_data = fr[i];
         rx_sof = (i == 0); rx_eof = (i == fr_len - 1);
         if (i == fr_len - 1) begin
            reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = 16'h0042;
         end
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; reg_wr = 1'b0;
      chk("R9 bad frame flagged", st_crc_err, 1);
      read_reg(1'b0, v); chk("R9 write wins", v, 16'h0042);

      @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule